// File: doc/BRIEF.md
# Voice Activity Gate with Shift-Based Pre-Emphasis

This block sits at the head of a speech feature pipeline. It takes signed audio samples (nominally 8 kHz, in capture windows of 8000 samples) and cuts the stream into consecutive segments. Each segment has a configurable number of samples. While a segment arrives, its samples go into a local buffer and their squares are summed. When the segment is complete, the summed energy is compared against a programmable threshold. A quiet segment is flushed and produces nothing. A loud segment is replayed from the buffer through a first-order high-boost filter, y[n] = x[n] - (15/16)·x[n-1]. The 15/16 product is built as x[n-1] minus x[n-1] shifted right arithmetically by four, so the filter needs no multiplier.

Both sides of the block use valid/ready handshakes. The output carries one filtered sample per transfer, plus a marker on the first sample of every segment that is kept. The two configuration inputs, segment length and energy threshold, are captured when a segment's first sample is accepted. They can therefore change between segments without corrupting a segment that is already in flight.

Top module: `voice_gate_emph`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A segment holds exactly the effective length in samples. The effective length is `cfg_seg_len`, except that 0 or any value above MAX_SEG (default 32) means MAX_SEG. Both configuration inputs are sampled on the handshake of a segment's first sample.
- R3: Segment energy is the exact, non-wrapping sum of the squares of its samples. A segment is kept when its energy is greater than or equal to the threshold, so an energy equal to the threshold is kept.
- R4: A segment whose energy is below the threshold produces no output transfer at all, and the next segment is accepted normally.
- R5: A kept segment emits exactly its effective length of samples, in arrival order. `out_first` is 1 on the first of them and 0 on all the others.
- R6: Each output equals x[n] - (x[n-1] - (x[n-1] >>> 4)), where >>> is an arithmetic shift and x[n-1] is the previous sample of the same segment.
- R7: The filter history is zero for the first sample of every kept segment, so that output equals its input sample.
- R8: Filter results beyond the signed SAMPLE_W range are clamped: to 32767 above and to -32768 below (for 16-bit samples).
- R9: While `out_valid` is 1 and `out_ready` is 0, the output sample and marker hold steady into the next cycle. `in_ready` is never 1 while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_seg_len | input | LEN_W (7) | Requested samples per segment |
| cfg_thresh | input | ENERGY_W (37) | Minimum energy for a segment to be kept |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_sample | input | SAMPLE_W (16) | Signed input sample |
| out_valid | output | 1 | Filtered sample offered |
| out_ready | input | 1 | Downstream takes the filtered sample |
| out_sample | output | SAMPLE_W (16) | Signed filtered sample |
| out_first | output | 1 | First sample of a kept segment |

## Verification
The bench goes after the energy comparison at exactly the threshold and one above it. A design using a strict comparison would lose the first of these segments, and one that ignores the threshold would emit the second. It drives full-scale samples of opposite sign back to back, where a design without clamping wraps to the wrong sign. It also sends loud segments after quiet ones, where a filter that keeps its history from the dropped or previous segment produces a wrong first output. Segment lengths of 0 and above the buffer depth, combined with heavy random backpressure, expose miscounted segments, reordered samples and output values that change while stalled.

// File: rtl/vg_pkg.sv
package vg_pkg;
   typedef enum logic [1:0] {
      ST_FILL   = 2'd0,
      ST_DECIDE = 2'd1,
      ST_DRAIN  = 2'd2
   } vg_state_e;
endpackage

// File: rtl/vg_energy_acc.sv
module vg_energy_acc #(
   parameter int SAMPLE_W = 16,
   parameter int ENERGY_W = 37
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       add_en,
   input  logic signed [SAMPLE_W-1:0] sample,
   output logic [ENERGY_W-1:0]        energy
);
   localparam int SQ_W = 2 * SAMPLE_W;

   if (ENERGY_W < SQ_W) begin : g_bad_width
      $error("vg_energy_acc: ENERGY_W must hold at least one square");
   end

   logic signed [SQ_W-1:0] sq;
   logic [ENERGY_W-1:0]    acc;

   assign sq     = sample * sample;
   assign energy = acc;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) acc <= '0;
      else if (add_en)   acc <= acc + {{(ENERGY_W-SQ_W){1'b0}}, sq};
   end

   // R3: summing never wraps, so the total cannot shrink while adding
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && !clr) |=> (energy >= $past(energy)));
endmodule

// File: rtl/vg_seg_buffer.sv
module vg_seg_buffer #(
   parameter int SAMPLE_W = 16,
   parameter int DEPTH    = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr_en,
   input  logic signed [SAMPLE_W-1:0] wr_data,
   input  logic                       rd_adv,
   output logic signed [SAMPLE_W-1:0] rd_data
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("vg_seg_buffer: DEPTH must be at least 2");
   end

   logic signed [SAMPLE_W-1:0] mem [DEPTH];
   logic [AW-1:0]              wr_ptr;
   logic [AW-1:0]              rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
         if (rd_adv) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/vg_preemph.sv
module vg_preemph #(
   parameter int SAMPLE_W = 16,
   parameter int SHIFT    = 4,
   parameter bit EMPH_EN  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hist_clr,
   input  logic                       adv,
   input  logic signed [SAMPLE_W-1:0] x,
   output logic signed [SAMPLE_W-1:0] y
);
   localparam int EW = SAMPLE_W + 2;

   if (SHIFT < 1 || SHIFT >= SAMPLE_W) begin : g_bad_shift
      $error("vg_preemph: SHIFT out of range");
   end

   if (EMPH_EN) begin : g_filter
      localparam logic signed [EW-1:0] MAXV = $signed({3'b000, {(SAMPLE_W-1){1'b1}}});
      localparam logic signed [EW-1:0] MINV = $signed({3'b111, {(SAMPLE_W-1){1'b0}}});

      logic signed [SAMPLE_W-1:0] hist;
      logic signed [EW-1:0]       xe, he, scaled, diff;

      always_ff @(posedge clk) begin
         if (!rst_n || hist_clr) hist <= '0;
         else if (adv)           hist <= x;
      end

      assign xe     = $signed({{2{x[SAMPLE_W-1]}}, x});
      assign he     = $signed({{2{hist[SAMPLE_W-1]}}, hist});
      assign scaled = he - (he >>> SHIFT);
      assign diff   = xe - scaled;

      always_comb begin
         if (diff > MAXV)      y = MAXV[SAMPLE_W-1:0];
         else if (diff < MINV) y = MINV[SAMPLE_W-1:0];
         else                  y = diff[SAMPLE_W-1:0];
      end
   end else begin : g_bypass
      assign y = x;
   end
endmodule

// File: rtl/voice_gate_emph.sv
module voice_gate_emph #(
   parameter int SAMPLE_W = 16,
   parameter int MAX_SEG  = 32,
   parameter int SHIFT    = 4,
   parameter bit EMPH_EN  = 1'b1,
   parameter int LEN_W    = $clog2(MAX_SEG) + 2,
   parameter int ENERGY_W = 2 * SAMPLE_W + $clog2(MAX_SEG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LEN_W-1:0]           cfg_seg_len,
   input  logic [ENERGY_W-1:0]        cfg_thresh,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic signed [SAMPLE_W-1:0] in_sample,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic signed [SAMPLE_W-1:0] out_sample,
   output logic                       out_first
);
   import vg_pkg::*;

   if (MAX_SEG < 2) begin : g_bad_seg
      $error("voice_gate_emph: MAX_SEG must be at least 2");
   end
   if (LEN_W <= $clog2(MAX_SEG + 1) - 1) begin : g_bad_len
      $error("voice_gate_emph: LEN_W too narrow for MAX_SEG");
   end

   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_SEG);

   vg_state_e             state;
   logic [LEN_W-1:0]      cnt, len_q, eff_cfg, cur_len;
   logic [ENERGY_W-1:0]   thr_q, energy;
   logic                  in_fire, out_fire, keep, buf_clr, hist_clr;
   logic signed [SAMPLE_W-1:0] buf_data;

   assign eff_cfg  = (cfg_seg_len == '0 || cfg_seg_len > MAX_LEN) ? MAX_LEN : cfg_seg_len;
   assign cur_len  = (cnt == '0) ? eff_cfg : len_q;
   assign in_ready = (state == ST_FILL);
   assign out_valid = (state == ST_DRAIN);
   assign out_first = out_valid && (cnt == '0);
   assign in_fire  = in_valid && in_ready;
   assign out_fire = out_valid && out_ready;
   assign keep     = (energy >= thr_q);
   assign hist_clr = (state == ST_DECIDE) && keep;
   assign buf_clr  = ((state == ST_DECIDE) && !keep) ||
                     (out_fire && (cnt + 1'b1 == len_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_FILL;
         cnt   <= '0;
         len_q <= MAX_LEN;
         thr_q <= '0;
      end else begin
         case (state)
            ST_FILL: if (in_fire) begin
               if (cnt == '0) begin
                  len_q <= eff_cfg;
                  thr_q <= cfg_thresh;
               end
               if (cnt + 1'b1 == cur_len) begin
                  cnt   <= '0;
                  state <= ST_DECIDE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DECIDE: begin
               cnt   <= '0;
               state <= keep ? ST_DRAIN : ST_FILL;
            end
            ST_DRAIN: if (out_fire) begin
               if (cnt + 1'b1 == len_q) begin
                  cnt   <= '0;
                  state <= ST_FILL;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_FILL;
         endcase
      end
   end

   vg_energy_acc #(.SAMPLE_W(SAMPLE_W), .ENERGY_W(ENERGY_W)) u_energy (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state == ST_DECIDE),
      .add_en (in_fire),
      .sample (in_sample),
      .energy (energy)
   );

   vg_seg_buffer #(.SAMPLE_W(SAMPLE_W), .DEPTH(MAX_SEG)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (buf_clr),
      .wr_en   (in_fire),
      .wr_data (in_sample),
      .rd_adv  (out_fire),
      .rd_data (buf_data)
   );

   vg_preemph #(.SAMPLE_W(SAMPLE_W), .SHIFT(SHIFT), .EMPH_EN(EMPH_EN)) u_emph (
      .clk      (clk),
      .rst_n    (rst_n),
      .hist_clr (hist_clr),
      .adv      (out_fire),
      .x        (buf_data),
      .y        (out_sample)
   );

   // R2: a partly filled segment never counts past its latched length
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && cnt != '0) |-> (cnt < len_q));
   // R5: every replay opens with the segment marker
   assert_first_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> out_first);
   // R9: output held steady under backpressure
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_first)));
   // R9: intake and replay never overlap
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));
endmodule

// File: tb/voice_gate_emph_tb.sv
module voice_gate_emph_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SW   = 16;
   localparam int MAXS = 32;
   localparam int LW   = $clog2(MAXS) + 2;
   localparam int EW   = 2 * SW + $clog2(MAXS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LW-1:0] cfg_seg_len = '0;
   logic [EW-1:0] cfg_thresh = '0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic signed [SW-1:0] in_sample = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic signed [SW-1:0] out_sample;
   logic out_first;

   int checks = 0;
   int errors = 0;
   int ready_pct = 100;
   bit done = 1'b0;

   int sent_q[$];
   int got_d[$];
   bit got_f[$];
   int exp_d[$];
   bit exp_f[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   voice_gate_emph dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_seg_len(cfg_seg_len), .cfg_thresh(cfg_thresh),
      .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
      .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
      .out_first(out_first)
   );

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // random backpressure
   always @(negedge clk) out_ready <= (int'($urandom % 100) < ready_pct);

   // monitor: samples between edges, after inputs settle
   bit prev_stall = 1'b0;
   logic signed [SW-1:0] prev_d;
   bit prev_f;
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         if (prev_stall) begin
            check(out_valid && out_sample == prev_d && out_first == prev_f,
                  "R9 stall hold", out_sample, prev_d);
         end
         if (out_valid) check(!in_ready, "R9 in_ready low during output", in_ready, 0);
         if (out_valid && out_ready) begin
            got_d.push_back(int'(out_sample));
            got_f.push_back(out_first);
         end
         prev_stall = out_valid && !out_ready;
         prev_d = out_sample;
         prev_f = out_first;
      end
   end

   task automatic send(int s);
      bit acc = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      in_sample = SW'(s);
      in_valid  = 1'b1;
      while (!acc) begin
         #1;
         acc = in_ready;
         @(negedge clk);
      end
      in_valid = 1'b0;
      sent_q.push_back(s);
   endtask

   function automatic int sat16(int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic void build_expected(int len_cfg, longint thr);
      int eff = (len_cfg == 0 || len_cfg > MAXS) ? MAXS : len_cfg;
      for (int b = 0; b + eff <= sent_q.size(); b += eff) begin
         longint e = 0;
         for (int k = 0; k < eff; k++) e += longint'(sent_q[b+k]) * longint'(sent_q[b+k]);
         if (e >= thr) begin
            int p = 0;
            for (int k = 0; k < eff; k++) begin
               int x = sent_q[b+k];
               exp_d.push_back(sat16(x - (p - (p >>> 4))));
               exp_f.push_back(k == 0);
               p = x;
            end
         end
      end
   endfunction

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (!in_ready || out_valid) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_phase(int len_cfg, longint thr, string req);
      wait_idle();
      build_expected(len_cfg, thr);
      check(got_d.size() == exp_d.size(), {req, " output count"}, got_d.size(), exp_d.size());
      for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
         check(got_d[i] == exp_d[i], {req, " sample value"}, got_d[i], exp_d[i]);
         check(got_f[i] == exp_f[i], {req, " R5 first marker"}, got_f[i], exp_f[i]);
      end
      sent_q.delete(); got_d.delete(); got_f.delete(); exp_d.delete(); exp_f.delete();
   endtask

   task automatic set_cfg(int len, longint thr);
      cfg_seg_len = LW'(len);
      cfg_thresh  = EW'(thr);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: reset state
      check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

      // R5 R6 R7: all kept, random samples
      ready_pct = 70;
      set_cfg(8, 0);
      for (int i = 0; i < 32; i++) send(int'($urandom_range(0, 40000)) - 20000);
      finish_phase(8, 0, "R6 R7 random");

      // R3 R4: alternating loud and quiet segments
      set_cfg(16, 1000);
      for (int s = 0; s < 6; s++)
         for (int i = 0; i < 16; i++)
            send((s % 2 == 0) ? int'($urandom_range(0, 3)) * 0 + int'($urandom_range(0, 6)) - 3
                              : int'($urandom_range(0, 20000)) - 10000);
      finish_phase(16, 1000, "R3 R4 gating");

      // R3: energy exactly equal to threshold is kept
      set_cfg(4, 400);
      for (int i = 0; i < 4; i++) send(10);
      finish_phase(4, 400, "R3 equal threshold");

      // R3 R4: one above threshold dropped, following loud segment still kept
      set_cfg(4, 401);
      for (int i = 0; i < 4; i++) send(10);
      for (int i = 0; i < 4; i++) send(1000 - 300 * i);
      finish_phase(4, 401, "R4 drop then keep");

      // R8: saturation both directions, R7 history cleared between segments
      set_cfg(2, 0);
      send(-32768); send(32767);
      send(32767);  send(-32768);
      finish_phase(2, 0, "R8 saturation");

      // R2: length 0 means MAX_SEG, heavy backpressure
      ready_pct = 25;
      set_cfg(0, 0);
      for (int i = 0; i < 2 * MAXS; i++) send(int'($urandom_range(0, 65535)) - 32768);
      finish_phase(0, 0, "R2 zero length");

      // R2: oversized length clamped
      ready_pct = 50;
      set_cfg(40, 0);
      for (int i = 0; i < MAXS; i++) send(int'($urandom_range(0, 2000)) - 1000);
      finish_phase(40, 0, "R2 clamp length");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule